// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block steers every CPU memory access below 1 MB to one of three destinations: system RAM with full access, system RAM that only accepts reads, or the PCI bus. The choice is made by a combinational decode of the access address against a set of fixed windows in the upper 384 KB. Each window's handling comes from programmable attribute bits or from the system-management RAM control byte.

Software programs the attribute and control bytes through a byte-wide configuration port. A read path on the same port returns the current register contents and a memory-size byte. The system-management-mode input feeds straight into the decode, so the 128 KB graphics-area window follows it in the same cycle. A write aimed at a read-only shadow window raises a block flag and selects no target.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset the seven attribute bytes (offsets 0x59 to 0x5F) read 0x00 and the SMRAM control byte (offset 0x72) reads 0x02, so every shadow window and the 0xA0000 window go to PCI when SMM is inactive.
- R2: A configuration write lands in the byte at cfgAddr when that offset is 0x59 to 0x5F or 0x72. cfgRdData returns that byte combinationally. Any other offset reads 0x00, except 0x57 (see R10), and a write to it changes no readable byte.
- R3: Bits [5:4] of byte 0x59 select the handling of the 64 KB window 0xF0000 to 0xFFFFF.
- R4: For i from 0 to 11, the 16 KB window starting at 0xC0000 + i*0x4000 is controlled by byte 0x5A + (i>>1). Even i uses bits [1:0] and odd i uses bits [5:4].
- R5: Target codes are 0 none, 1 RAM read/write, 2 RAM read-only, 3 PCI. Attribute 3 gives code 1, attribute 1 gives code 2 for reads, and attribute 0 or 2 gives code 3.
- R6: A write (cpuWrite=1) to a window with attribute 1 gives target 0 and wrBlock=1. In every other case wrBlock is 0.
- R7: The window 0xA0000 to 0xBFFFF gives code 1 when (smmActive=1 and SMRAM bit 3=1) or SMRAM bit 6=1. Otherwise it gives code 3.
- R8: A change of smmActive alters the 0xA0000 window result in the same cycle, with no clock edge in between.
- R9: Addresses below 0xA0000 give code 1 when under the LOW_RAM_TOP parameter (default 0x9F000) and code 3 from LOW_RAM_TOP upward.
- R10: Offset 0x57 reads RAM_MB/8 saturated at 255 (0xFF with the default 4096 MB) and ignores writes.
- R11: A configuration write takes effect at the rising clock edge that samples cfgWrEn. Before that edge the decode still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpuAddr | input | 20 | CPU memory address |
| cpuWrite | input | 1 | 1 for a write access, 0 for a read |
| smmActive | input | 1 | System-management mode active |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte offset for writes and reads |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration byte at cfgAddr |
| target | output | 2 | Selected destination code (R5) |
| wrBlock | output | 1 | Write refused by a read-only window |

## Verification
The assertions assume that cpuAddr, cpuWrite and smmActive hold known values whenever reset is released. They also assume that the configuration inputs settle between clock edges. The bench meets both assumptions by driving every input on the falling edge and releasing reset on a falling edge. It samples the combinational outputs a short delay after each change, so each result reflects a single stable input set.

// File: rtl/lmd_pkg.sv
package lmd_pkg;
  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_RAM_RW = 2'd1,
    TGT_RAM_RO = 2'd2,
    TGT_PCI    = 2'd3
  } tgt_e;

  localparam int ATTR_BYTES   = 7;
  localparam int NUM_SMALL    = 12;
  localparam int NUM_WIN      = NUM_SMALL + 1;
  localparam logic [7:0] ATTR_BASE  = 8'h59;
  localparam logic [7:0] SMRAM_OFF  = 8'h72;
  localparam logic [7:0] MEMSZ_OFF  = 8'h57;
  localparam logic [7:0] SMRAM_RST  = 8'h02;
  localparam int SMRAM_SMM_BIT  = 3;
  localparam int SMRAM_OPEN_BIT = 6;

  typedef struct packed {
    logic [ATTR_BYTES-1:0] attrWe;
    logic                  smramWe;
    logic [7:0]            data;
  } cfg_strobe_t;
endpackage

// File: rtl/lmd_ctrl.sv
module lmd_ctrl
  import lmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgAddr,
  input  logic [7:0]  cfgWrData,
  output cfg_strobe_t strb
);
  logic [7:0] relOff;
  assign relOff = cfgAddr - ATTR_BASE;

  generate
    for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_we
      assign strb.attrWe[b] = cfgWrEn && (relOff == 8'(b));
    end
  endgenerate

  assign strb.smramWe = cfgWrEn && (cfgAddr == SMRAM_OFF);
  assign strb.data    = cfgWrData;

  // R2: at most one register strobed per write
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.attrWe, strb.smramWe}));
  // R10: the memory size offset never produces a strobe
  p_memsz_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAddr == MEMSZ_OFF) |-> !(|{strb.attrWe, strb.smramWe}));
endmodule

// File: rtl/lmd_datapath.sv
module lmd_datapath
  import lmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] LOW_RAM_TOP = 20'h9F000,
  parameter int RAM_MB = 4096
)(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_strobe_t       strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic              smmActive,
  input  logic [7:0]        cfgAddr,
  output logic [7:0]        cfgRdData,
  output tgt_e              target,
  output logic              wrBlock
);
  localparam logic [ADDR_W-1:0] SMW_BASE  = ADDR_W'(20'hA0000);
  localparam logic [ADDR_W-1:0] SHD_BASE  = ADDR_W'(20'hC0000);
  localparam logic [ADDR_W-1:0] BIOS_BASE = ADDR_W'(20'hF0000);
  localparam int SMALL_SHIFT = 14;
  localparam int MEMSZ_RAW   = RAM_MB / 8;
  localparam logic [7:0] MEMSZ_BYTE = (MEMSZ_RAW > 255) ? 8'hFF : 8'(MEMSZ_RAW);

  logic [7:0] attrReg [ATTR_BYTES];
  logic [7:0] smramReg;
  logic [1:0] winAttr [NUM_WIN];

  generate
    for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_attr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               attrReg[b] <= 8'h00;
        else if (strb.attrWe[b])  attrReg[b] <= strb.data;
      end
    end
    for (genvar w = 0; w < NUM_SMALL; w++) begin : g_win
      assign winAttr[w+1] = attrReg[1 + w/2][(w%2)*4 +: 2];
    end
  endgenerate
  assign winAttr[0] = attrReg[0][5:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            smramReg <= SMRAM_RST;
    else if (strb.smramWe) smramReg <= strb.data;
  end

  // configuration read mux
  logic [7:0] relOff;
  assign relOff = cfgAddr - ATTR_BASE;
  always_comb begin
    cfgRdData = 8'h00;
    if (relOff < 8'(ATTR_BYTES))   cfgRdData = attrReg[relOff[2:0]];
    else if (cfgAddr == SMRAM_OFF) cfgRdData = smramReg;
    else if (cfgAddr == MEMSZ_OFF) cfgRdData = MEMSZ_BYTE;
  end

  // address decode
  logic inBios, inShadow, inSmw;
  logic [ADDR_W-1:0] shdOff;
  logic [3:0] shdIdx;
  logic [1:0] selAttr;
  logic smwOpen;

  assign inBios   = cpuAddr >= BIOS_BASE;
  assign inShadow = (cpuAddr >= SHD_BASE) && !inBios;
  assign inSmw    = (cpuAddr >= SMW_BASE) && (cpuAddr < SHD_BASE);
  assign shdOff   = cpuAddr - SHD_BASE;
  assign shdIdx   = shdOff[SMALL_SHIFT +: 4];
  assign smwOpen  = (smmActive && smramReg[SMRAM_SMM_BIT]) || smramReg[SMRAM_OPEN_BIT];

  always_comb begin
    selAttr = 2'd0;
    if (inBios)        selAttr = winAttr[0];
    else if (inShadow) selAttr = winAttr[4'd1 + shdIdx];
  end

  always_comb begin
    target  = TGT_PCI;
    wrBlock = 1'b0;
    if (inBios || inShadow) begin
      unique case (selAttr)
        2'd3: target = TGT_RAM_RW;
        2'd1: begin
          if (cpuWrite) begin
            target  = TGT_NONE;
            wrBlock = 1'b1;
          end else begin
            target = TGT_RAM_RO;
          end
        end
        default: target = TGT_PCI;
      endcase
    end else if (inSmw) begin
      target = smwOpen ? TGT_RAM_RW : TGT_PCI;
    end else begin
      target = (cpuAddr < LOW_RAM_TOP) ? TGT_RAM_RW : TGT_PCI;
    end
  end

  // R6: block flag only on a write, and only with no target
  p_block_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrBlock |-> (cpuWrite && target == TGT_NONE));
  // R5: a read-only selection is never given to a write
  p_ro_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (target == TGT_RAM_RO) |-> !cpuWrite);
  // R7: override bit opens the SMRAM window regardless of mode
  p_smram_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smramReg[SMRAM_OPEN_BIT] && inSmw) |-> target == TGT_RAM_RW);
  // R9: low memory under the top always reaches RAM
  p_low_ram_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuAddr < LOW_RAM_TOP) |-> target == TGT_RAM_RW);
  // R11: SMRAM byte holds while no write strobe was seen
  p_smram_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.smramWe |=> $stable(smramReg));
endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
  import lmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] LOW_RAM_TOP = 20'h9F000,
  parameter int RAM_MB = 4096
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic              smmActive,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  output logic [1:0]        target,
  output logic              wrBlock
);
  cfg_strobe_t strb;
  tgt_e tgt;

  lmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .strb(strb)
  );

  lmd_datapath #(.ADDR_W(ADDR_W), .LOW_RAM_TOP(LOW_RAM_TOP), .RAM_MB(RAM_MB)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cpuAddr(cpuAddr),
    .cpuWrite(cpuWrite), .smmActive(smmActive), .cfgAddr(cfgAddr),
    .cfgRdData(cfgRdData), .target(tgt), .wrBlock(wrBlock)
  );

  assign target = tgt;
endmodule

// File: tb/legacy_mem_decoder_bench.sv
module legacy_mem_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] cpuAddr = '0;
  logic cpuWrite = 1'b0, smmActive = 1'b0, cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = '0, cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic [1:0] target;
  logic wrBlock;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_mem_decoder u_legacy_mem_decoder (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .smmActive(smmActive), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .target(target), .wrBlock(wrBlock)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [7:0] off, logic [7:0] val);
    @(negedge clk);
    cfgAddr = off; cfgWrData = val; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic readCfg(logic [7:0] off, string tag, int exp);
    cfgAddr = off; #1;
    check(tag, cfgRdData, exp);
  endtask

  task automatic access(logic [19:0] a, logic wr, string tag, int expT, int expB);
    cpuAddr = a; cpuWrite = wr; #1;
    check(tag, target, expT);
    check({tag, " block"}, wrBlock, expB);
  endtask

  task automatic test_reset();
    for (int b = 0; b < 7; b++) readCfg(8'h59 + 8'(b), "R1 attr reset", 0);
    readCfg(8'h72, "R1 smram reset", 8'h02);
    access(20'hF0000, 0, "R1 bios pci", 3, 0);
    access(20'hC4000, 1, "R1 shadow pci", 3, 0);
    access(20'hA0000, 0, "R1 smw pci", 3, 0);
  endtask

  task automatic test_bios();
    cfgWrite(8'h59, 8'h30);
    access(20'hF8000, 1, "R3 bios rw", 1, 0);
    access(20'hEFFFF, 0, "R3 below bios unaffected", 3, 0);
    cfgWrite(8'h59, 8'hCF);
    access(20'hFFFFF, 0, "R3 bios low bits ignored", 3, 0);
    cfgWrite(8'h59, 8'h10);
    access(20'hF0000, 0, "R5 bios ro read", 2, 0);
    access(20'hF0000, 1, "R6 bios ro write", 0, 1);
    cfgWrite(8'h59, 8'h20);
    access(20'hF1234, 0, "R5 attr2 pci", 3, 0);
  endtask

  task automatic test_shadow();
    // window i gets attribute (i*3+1)%4
    for (int b = 0; b < 6; b++) begin
      int ev = ((2*b)*3 + 1) % 4;
      int od = ((2*b+1)*3 + 1) % 4;
      cfgWrite(8'h5A + 8'(b), 8'((od << 4) | ev));
    end
    for (int i = 0; i < 12; i++) begin
      int at = (i*3 + 1) % 4;
      int expT = (at == 3) ? 1 : (at == 1) ? 2 : 3;
      access(20'hC0000 + 20'(i*20'h4000), 0, $sformatf("R4 win%0d lo", i), expT, 0);
      access(20'hC0000 + 20'(i*20'h4000) + 20'h3FFF, 0, $sformatf("R4 win%0d hi", i), expT, 0);
      if (at == 1) access(20'hC0000 + 20'(i*20'h4000), 1, $sformatf("R6 win%0d wr", i), 0, 1);
      else         access(20'hC0000 + 20'(i*20'h4000), 1, $sformatf("R5 win%0d wr", i), expT, 0);
    end
  endtask

  task automatic test_smram();
    cfgWrite(8'h72, 8'h08);
    smmActive = 0; access(20'hA0000, 0, "R7 bit3 no smm", 3, 0);
    smmActive = 1; access(20'hA0000, 0, "R8 smm rises same cycle", 1, 0);
    smmActive = 0; access(20'hBFFFF, 0, "R8 smm falls same cycle", 3, 0);
    cfgWrite(8'h72, 8'h40);
    access(20'hBFFFF, 1, "R7 override", 1, 0);
    cfgWrite(8'h72, 8'h00);
    smmActive = 1; access(20'hA8000, 0, "R7 smm without bit", 3, 0);
    smmActive = 0;
  endtask

  task automatic test_low();
    access(20'h00000, 1, "R9 zero", 1, 0);
    access(20'h9EFFF, 0, "R9 below top", 1, 0);
    access(20'h9F000, 0, "R9 at top", 3, 0);
    access(20'h9FFFF, 1, "R9 above top", 3, 0);
  endtask

  task automatic test_cfg_map();
    readCfg(8'h57, "R10 memsize", 8'hFF);
    cfgWrite(8'h57, 8'h11);
    readCfg(8'h57, "R10 memsize write ignored", 8'hFF);
    cfgWrite(8'h40, 8'hAA);
    readCfg(8'h40, "R2 unmapped read", 0);
    readCfg(8'h59, "R2 unmapped write no effect", 8'h20);
    readCfg(8'h60, "R2 past attr range", 0);
    cfgWrite(8'h5F, 8'h5A);
    readCfg(8'h5F, "R2 last attr byte", 8'h5A);
  endtask

  task automatic test_timing();
    cpuAddr = 20'hF0000; cpuWrite = 0;
    @(negedge clk);
    cfgAddr = 8'h59; cfgWrData = 8'h30; cfgWrEn = 1;
    #1 check("R11 before edge old", target, 3);
    @(negedge clk);
    cfgWrEn = 0;
    #1 check("R11 after edge new", target, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_bios();
    test_shadow();
    test_smram();
    test_low();
    test_cfg_map();
    test_timing();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule